// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers the sixteen interrupt pins of a four-slot PCI backplane (pins A to D on each slot) onto a small set of ISA interrupt request lines. Software configures the steering through eight routing bytes, one nibble per slot pin, written through a simple byte write port. The block then drives a 16-bit ISA request vector and a 16-bit level-conversion vector. The conversion vector tells a downstream edge-triggered interrupt controller which lines carry level-sensitive PCI interrupts that it must convert.

Each nibble holds a 3-bit line code and a conversion flag. Several pins may be steered to the same line, and the line is then the wired-OR of those pins. Both output vectors are combinational from the stored routing bytes and the pin inputs. A new routing byte therefore takes effect from the cycle after its write.

Top module: `pci_irq_steer`

## Requirements
- R1: After reset all eight routing bytes are zero, every slot pin is disabled, and `irq_req` and `irq_level` are both zero whatever the pins do.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_wdata` is stored in routing byte `cfg_idx` (0 to 7). The new routing shows on the outputs from that edge on, and a byte that is not written keeps its value.
- R3: Nibble bits 2:0 select the ISA line: 0 disabled, 1 IRQ5, 2 IRQ9, 3 IRQ10, 4 IRQ11, 5 IRQ12, 6 IRQ14, 7 IRQ15.
- R4: Byte index i belongs to slot i>>1. In an even byte the low nibble steers pin D and the high nibble steers pin C. In an odd byte the low nibble steers pin B and the high nibble steers pin A.
- R5: Pin inputs are active-low. `pin_n` bit slot*4+p carries pin p of that slot (p = 0 for A, 1 for B, 2 for C, 3 for D). A line is requested only while a pin steered to it is low.
- R6: When several pins are steered to one line, that line is requested while any of them is low.
- R7: Nibble bit 3 with a non-zero code sets the `irq_level` bit of the selected line. The bit is the OR over all nibbles steered to that line.
- R8: Lines 0 to 4, 6 to 8 and 13 are always zero in both `irq_req` and `irq_level`.
- R9: `irq_level` depends only on the routing bytes and does not follow the pin inputs.
- R10: A pin whose code is 0 is ignored: driving it low requests no line, and its bit 3 sets no conversion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Routing byte write strobe |
| cfg_idx | input | 3 | Routing byte index (slot*2 + 1 for pins A/B, slot*2 for pins C/D) |
| cfg_wdata | input | 8 | Routing byte value |
| pin_n | input | 16 | Active-low PCI interrupt pins, bit slot*4+pin |
| irq_req | output | 16 | ISA interrupt request vector, active-high |
| irq_level | output | 16 | Per-line level-to-edge conversion enable |

## Verification
A routing write and a change of the pins can fall in the same cycle. The bench provokes this by driving a new routing byte and a new pin pattern together at a falling edge. Before the rising edge, the request vector is judged against the old routing and the new pins. After the edge, both vectors are judged against the new routing, so the stored bytes never leak ahead of the clock.

// File: rtl/pci_irq_steer_pkg.sv
package pci_irq_steer_pkg;

    localparam int IRQ_LINES = 16;
    localparam int NIB_W     = 4;
    localparam int CODE_W    = 3;
    localparam int LINE_W    = $clog2(IRQ_LINES);

    // Lines a code can ever select: 5, 9, 10, 11, 12, 14, 15.
    localparam logic [IRQ_LINES-1:0] REACHABLE = 16'b1101_1110_0010_0000;

    typedef struct packed {
        logic              en;
        logic [LINE_W-1:0] line;
    } irq_sel_t;

    function automatic irq_sel_t decode_code(input logic [CODE_W-1:0] code);
        irq_sel_t s;
        s.en = 1'b1;
        case (code)
            3'd1:    s.line = 4'd5;
            3'd2:    s.line = 4'd9;
            3'd3:    s.line = 4'd10;
            3'd4:    s.line = 4'd11;
            3'd5:    s.line = 4'd12;
            3'd6:    s.line = 4'd14;
            3'd7:    s.line = 4'd15;
            default: begin
                s.en   = 1'b0;
                s.line = '0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/router_cfg_regs.sv
module router_cfg_regs #(
    parameter int NUM_BYTES = 8,
    localparam int IDX_W    = $clog2(NUM_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [7:0]                wr_data,
    output logic [NUM_BYTES-1:0][7:0] cfg_q
);

    typedef struct packed {
        logic [NUM_BYTES-1:0][7:0] bytes;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bytes[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.bytes;

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_q[$past(wr_idx)] == $past(wr_data));

    assert_hold_unwritten_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/router_pin_decode.sv
module router_pin_decode
    import pci_irq_steer_pkg::*;
(
    input  logic [NIB_W-1:0]     nibble,
    input  logic                 pin_n,
    output logic [IRQ_LINES-1:0] req_hit,
    output logic [IRQ_LINES-1:0] lvl_hit
);

    irq_sel_t sel;

    always_comb begin
        sel     = decode_code(nibble[CODE_W-1:0]);
        req_hit = '0;
        lvl_hit = '0;
        if (sel.en) begin
            req_hit[sel.line] = ~pin_n;
            lvl_hit[sel.line] = nibble[NIB_W-1];
        end
    end

endmodule

// File: rtl/pci_irq_steer.sv
module pci_irq_steer
    import pci_irq_steer_pkg::*;
#(
    parameter int NUM_SLOTS      = 4,
    localparam int PINS_PER_SLOT = 4,
    localparam int NUM_PINS      = NUM_SLOTS * PINS_PER_SLOT,
    localparam int NUM_BYTES     = NUM_SLOTS * 2,
    localparam int IDX_W         = $clog2(NUM_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [7:0]           cfg_wdata,
    input  logic [NUM_PINS-1:0]  pin_n,
    output logic [IRQ_LINES-1:0] irq_req,
    output logic [IRQ_LINES-1:0] irq_level
);

    logic [NUM_BYTES-1:0][7:0]         cfg;
    logic [NUM_PINS-1:0][IRQ_LINES-1:0] req_hits;
    logic [NUM_PINS-1:0][IRQ_LINES-1:0] lvl_hits;

    router_cfg_regs #(.NUM_BYTES(NUM_BYTES)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg)
    );

    // Pins A/B live in the odd byte of a slot, C/D in the even byte;
    // A and C take the high nibble.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar p = 0; p < PINS_PER_SLOT; p++) begin : g_pin
            localparam int BYTE_SEL = 2 * s + ((p < 2) ? 1 : 0);
            localparam bit HI_NIB   = (p % 2) == 0;
            logic [NIB_W-1:0] nib;
            assign nib = HI_NIB ? cfg[BYTE_SEL][7:4] : cfg[BYTE_SEL][3:0];

            router_pin_decode i_dec (
                .nibble  (nib),
                .pin_n   (pin_n[s*PINS_PER_SLOT+p]),
                .req_hit (req_hits[s*PINS_PER_SLOT+p]),
                .lvl_hit (lvl_hits[s*PINS_PER_SLOT+p])
            );
        end
    end

    always_comb begin
        irq_req   = '0;
        irq_level = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            irq_req   = irq_req   | req_hits[i];
            irq_level = irq_level | lvl_hits[i];
        end
    end

    assert_unreachable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req | irq_level) & ~REACHABLE) == '0);

    assert_idle_pins_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&pin_n) |-> (irq_req == '0));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_req == '0 && irq_level == '0));

    assert_level_needs_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == '0) |-> (irq_level == '0));

endmodule

// File: tb/test_pci_irq_steer.sv
module test_pci_irq_steer;

    localparam logic [15:0] REACH = 16'hDE20;

    logic        clk;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [7:0]  cfg_wdata;
    logic [15:0] pin_n;
    logic [15:0] irq_req;
    logic [15:0] irq_level;

    logic [7:0] m_regs [8];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    pci_irq_steer i_pci_irq_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .pin_n     (pin_n),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic int line_of(input int code);
        if (code == 1) return 5;
        else if (code <= 5) return code + 7;
        else return code + 8;
    endfunction

    function automatic logic [3:0] nib_of(input int p);
        int s, k, idx;
        s   = p / 4;
        k   = p % 4;
        idx = s * 2 + ((k < 2) ? 1 : 0);
        return (k % 2 == 0) ? m_regs[idx][7:4] : m_regs[idx][3:0];
    endfunction

    function automatic logic [15:0] exp_req(input logic [15:0] pins);
        logic [15:0] r;
        logic [3:0]  n;
        r = '0;
        for (int p = 0; p < 16; p++) begin
            n = nib_of(p);
            if (n[2:0] != 0 && !pins[p]) r[line_of(int'(n[2:0]))] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_lvl();
        logic [15:0] r;
        logic [3:0]  n;
        r = '0;
        for (int p = 0; p < 16; p++) begin
            n = nib_of(p);
            if (n[2:0] != 0 && n[3]) r[line_of(int'(n[2:0]))] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [7:0] val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 3'(idx);
        cfg_wdata = val;
        @(posedge clk);
        #1;
        m_regs[idx] = val;
        cfg_we = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0; pin_n = '1;
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state, pins idle and all asserted
        check("R1 req", irq_req, 16'h0);
        check("R1 lvl", irq_level, 16'h0);
        pin_n = '0; #1;
        check("R1 req all pins low", irq_req, 16'h0);
        pin_n = '1;

        // Sweep every pin, code and conversion flag (R3 R4 R5 R7 R8 R9 R10)
        for (int p = 0; p < 16; p++) begin
            for (int code = 0; code < 8; code++) begin
                for (int lv = 0; lv < 2; lv++) begin
                    int idx, k;
                    logic [3:0] nv;
                    logic [7:0] bv;
                    k   = p % 4;
                    idx = (p / 4) * 2 + ((k < 2) ? 1 : 0);
                    nv  = {1'(lv), 3'(code)};
                    bv  = (k % 2 == 0) ? {nv, 4'h0} : {4'h0, nv};
                    wr(idx, bv);
                    pin_n = '1; #1;
                    check("R5 idle", irq_req, 16'h0);
                    check("R7 lvl", irq_level, exp_lvl());
                    pin_n = ~(16'h1 << p); #1;
                    check(code == 0 ? "R10 ignored" : "R3 R4 route", irq_req, exp_req(pin_n));
                    check("R9 lvl ignores pins", irq_level, exp_lvl());
                    check("R8 unreachable", (irq_req | irq_level) & ~REACH, 16'h0);
                    pin_n = 16'h1 << p; #1;
                    check("R4 other pins", irq_req, 16'h0);
                    pin_n = '1;
                    wr(idx, 8'h00);
                end
            end
        end

        // R6: all pins share IRQ10, one with conversion flag
        for (int b = 0; b < 8; b++) wr(b, (b == 5) ? 8'h3B : 8'h33);
        for (int p = 0; p < 16; p++) begin
            pin_n = ~(16'h1 << p); #1;
            check("R6 shared", irq_req, 16'h0400);
            check("R7 shared lvl", irq_level, 16'h0400);
        end
        pin_n = '1;

        // R6 R7: random routings and pin patterns
        for (int it = 0; it < 150; it++) begin
            for (int b = 0; b < 8; b++) wr(b, 8'($urandom));
            pin_n = 16'($urandom); #1;
            check("R6 random req", irq_req, exp_req(pin_n));
            check("R7 random lvl", irq_level, exp_lvl());
        end

        // R2: write and pin change in the same cycle
        for (int it = 0; it < 60; it++) begin
            int idx;
            logic [7:0]  val;
            logic [15:0] pv;
            idx = int'($urandom % 8);
            val = 8'($urandom);
            pv  = 16'($urandom);
            @(negedge clk);
            cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = val; pin_n = pv;
            #1;
            check("R2 old routing before edge", irq_req, exp_req(pv));
            @(posedge clk);
            #1;
            m_regs[idx] = val;
            cfg_we = 1'b0;
            check("R2 new routing req", irq_req, exp_req(pv));
            check("R2 new routing lvl", irq_level, exp_lvl());
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule